// File: doc/BRIEF.md
# Multichannel Acquisition Scan Controller

This block is the host-side master for an eight-input, twelve-bit sampling converter. The converter has a byte-wide, three-state result bus and a single read/convert strobe. The controller visits the analog inputs in ascending order. For each input it first drives the three-bit channel address and waits out a setup window. It then pulses the read/convert strobe low to start a conversion, and watches the converter's busy flag rise and later fall. After that it collects the twelve-bit result through two byte reads, steered by a byte-select line. Each finished result is offered, tagged with its channel number, on a valid/ready stream toward the rest of the chip.

Every analog-side timing minimum is a parameter counted in system clock cycles: address setup, strobe low width, strobe-high-before-read and byte-select-before-read. The controller also watches for a converter that never starts or never finishes. It bounds both waits with maximum counts, raises a one-cycle error pulse and abandons that attempt. Scanning runs while the enable input is high. Dropping the enable lets the channel in progress complete and deliver its sample, and no further conversion is started.

Top module: `das_scan_ctrl`

## Requirements
- R1: The channel address `muxAddr` is the plain binary channel number. Successive samples come from channels 0,1,...,7,0,... and the channel only advances when a sample is accepted.
- R2: `muxAddr` is stable for at least `SETUP_CYC` clock cycles before `convN` falls.
- R3: Each conversion start holds `convN` low for exactly `PULSE_CYC` cycles, and `convN` is high at all other times.
- R4: `muxAddr` does not change while `convN` is low, while `busyIn` is high, or at any time other than the acceptance of a sample.
- R5: After `busyIn` has risen and then fallen, the first read uses `byteSel`=0 with `convN` high for at least `RDHI_CYC` cycles. It places `dataBus[7:0]` into sample bits 11..4.
- R6: The second read drives `byteSel`=1 for `RDLO_CYC` cycles before sampling. It places `dataBus[7:4]` into sample bits 3..0, and `dataBus[3:0]` of that read has no effect on the result.
- R7: A result is presented as `sampleData[14:12]` = channel and `sampleData[11:0]` = sample. `sampleValid` and `sampleData` stay constant until `sampleReady` is high, and no conversion starts while a result waits.
- R8: If `busyIn` is not high within `RISE_MAX` cycles after `convN` returns high, `timeoutErr` pulses for one cycle exactly `PULSE_CYC+RISE_MAX` cycles after `convN` fell. No sample is produced, and the next attempt uses the same channel.
- R9: If `busyIn` stays high for `FALL_MAX` cycles, `timeoutErr` pulses for one cycle. No sample is produced, and the next attempt uses the same channel.
- R10: Deasserting `scanEn` after a conversion has started lets that channel's sample be delivered, and no further conversion starts.
- R11: After reset `convN`=1, `byteSel`=0, `muxAddr`=0, `sampleValid`=0 and `timeoutErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | Continuous scanning enable |
| busyIn | input | 1 | Converter busy flag, high during conversion |
| dataBus | input | 8 | Converter result byte bus |
| sampleReady | input | 1 | Downstream accepts the presented sample |
| muxAddr | output | 3 | Analog channel address |
| convN | output | 1 | Read/convert strobe, low starts a conversion |
| byteSel | output | 1 | 0 selects high byte, 1 selects low nibble |
| sampleValid | output | 1 | Sample on sampleData is valid |
| sampleData | output | 15 | {channel, 12-bit sample} |
| timeoutErr | output | 1 | One-cycle pulse on a busy-flag timeout |

## Verification
The bench builds the controller with short windows: setup 3, strobe 2, rise limit 6, fall limit 40 and both read waits 2. A behavioural converter finishes in about twenty cycles. With these values a full wrap of all eight channels, a rise timeout and a fall timeout each fit in a few hundred cycles. The exact error latency of the rise timeout becomes a single countable value. The converter drives a nonzero pattern on the padded lines of the second read, and channel values are chosen so that full-scale and zero results both occur, which exposes any leak of the padding into the sample.

// File: rtl/das_scan_pkg.sv
`timescale 1ns/1ps
package das_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_RISE, ST_FALL, ST_RDHI, ST_RDLO, ST_OUT
  } scanState_t;

  typedef enum logic [2:0] {
    CNT_SETUP, CNT_PULSE, CNT_RISE, CNT_FALL, CNT_RDHI, CNT_RDLO
  } cntSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    cntLoad;
    cntSel_t cntSel;
    logic    capHi;
    logic    capLo;
    logic    chAdvance;
  } dpCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/das_scan_dp.sv
`timescale 1ns/1ps
module das_scan_dp
  import das_scan_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int SAMPLE_W  = 12,
  parameter int BUS_W     = 8,
  parameter int SETUP_CYC = 13,
  parameter int PULSE_CYC = 13,
  parameter int RISE_MAX  = 250,
  parameter int FALL_MAX  = 4000,
  parameter int RDHI_CYC  = 13,
  parameter int RDLO_CYC  = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  input  logic [BUS_W-1:0]         dataBus,
  output logic                     cntZero,
  output logic [CH_W-1:0]          chSel,
  output logic [CH_W+SAMPLE_W-1:0] beat
);
  localparam int LO_W   = SAMPLE_W - BUS_W;
  localparam int PAD_W  = BUS_W - LO_W;
  localparam int MAXCNT = maxOf(maxOf(maxOf(SETUP_CYC, PULSE_CYC), maxOf(RISE_MAX, FALL_MAX)),
                                maxOf(RDHI_CYC, RDLO_CYC));
  localparam int CNT_W  = $clog2(MAXCNT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic [CH_W-1:0]  chReg;
  logic [BUS_W-1:0] hiReg;
  logic [LO_W-1:0]  loReg;
  logic             unusedPadBits;

  always_comb begin
    unique case (ctl.cntSel)
      CNT_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      CNT_PULSE: loadVal = CNT_W'(PULSE_CYC - 1);
      CNT_RISE:  loadVal = CNT_W'(RISE_MAX - 1);
      CNT_FALL:  loadVal = CNT_W'(FALL_MAX - 1);
      CNT_RDHI:  loadVal = CNT_W'(RDHI_CYC - 1);
      CNT_RDLO:  loadVal = CNT_W'(RDLO_CYC - 1);
      default:   loadVal = '0;
    endcase
  end

  // window counter: load N-1, count down to zero
  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (ctl.cntLoad)   cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  // channel pointer wraps naturally at 2**CH_W
  always_ff @(posedge clk) begin
    if (!rstN)              chReg <= '0;
    else if (ctl.chAdvance) chReg <= chReg + 1'b1;
  end
  assign chSel = chReg;

  // byte assembly: full upper byte, then upper lines of the second read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else begin
      if (ctl.capHi) hiReg <= dataBus;
      if (ctl.capLo) loReg <= dataBus[BUS_W-1 -: LO_W];
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign unusedPadBits = ^dataBus[PAD_W-1:0];
    end else begin : g_nopad
      assign unusedPadBits = 1'b0;
    end
  endgenerate

  assign beat = {chReg, hiReg, loReg};

endmodule

// File: rtl/das_scan_fsm.sv
`timescale 1ns/1ps
module das_scan_fsm
  import das_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   scanEn,
  input  logic   busyIn,
  input  logic   sampleReady,
  input  logic   cntZero,
  output dpCtl_t ctl,
  output logic   convN,
  output logic   byteSel,
  output logic   sampleValid,
  output logic   timeoutErr
);
  scanState_t st, stNext;
  logic       errSet;
  logic       convNQ, byteSelQ, errQ;

  always_comb begin
    stNext = st;
    ctl    = '0;
    errSet = 1'b0;
    unique case (st)
      ST_IDLE: if (scanEn) begin
        stNext = ST_SETUP; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_SETUP;
      end
      ST_SETUP: if (cntZero) begin
        stNext = ST_PULSE; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_PULSE;
      end
      ST_PULSE: if (cntZero) begin
        stNext = ST_RISE; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_RISE;
      end
      ST_RISE: begin
        if (busyIn) begin
          stNext = ST_FALL; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_FALL;
        end else if (cntZero) begin
          stNext = ST_IDLE; errSet = 1'b1;
        end
      end
      ST_FALL: begin
        if (!busyIn) begin
          stNext = ST_RDHI; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_RDHI;
        end else if (cntZero) begin
          stNext = ST_IDLE; errSet = 1'b1;
        end
      end
      ST_RDHI: if (cntZero) begin
        stNext = ST_RDLO; ctl.capHi = 1'b1; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_RDLO;
      end
      ST_RDLO: if (cntZero) begin
        stNext = ST_OUT; ctl.capLo = 1'b1;
      end
      ST_OUT: if (sampleReady) begin
        ctl.chAdvance = 1'b1;
        if (scanEn) begin
          stNext = ST_SETUP; ctl.cntLoad = 1'b1; ctl.cntSel = CNT_SETUP;
        end else begin
          stNext = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  // pin-facing outputs registered from the next state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      convNQ   <= 1'b1;
      byteSelQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      st       <= stNext;
      convNQ   <= (stNext != ST_PULSE);
      byteSelQ <= (stNext == ST_RDLO);
      errQ     <= errSet;
    end
  end

  assign convN       = convNQ;
  assign byteSel     = byteSelQ;
  assign timeoutErr  = errQ;
  assign sampleValid = (st == ST_OUT);

endmodule

// File: rtl/das_scan_ctrl.sv
`timescale 1ns/1ps
module das_scan_ctrl
  import das_scan_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int SAMPLE_W  = 12,
  parameter int BUS_W     = 8,
  parameter int SETUP_CYC = 13,
  parameter int PULSE_CYC = 13,
  parameter int RISE_MAX  = 250,
  parameter int FALL_MAX  = 4000,
  parameter int RDHI_CYC  = 13,
  parameter int RDLO_CYC  = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     scanEn,
  input  logic                     busyIn,
  input  logic [BUS_W-1:0]         dataBus,
  input  logic                     sampleReady,
  output logic [CH_W-1:0]          muxAddr,
  output logic                     convN,
  output logic                     byteSel,
  output logic                     sampleValid,
  output logic [CH_W+SAMPLE_W-1:0] sampleData,
  output logic                     timeoutErr
);
  dpCtl_t ctl;
  logic   cntZero;

  das_scan_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .scanEn     (scanEn),
    .busyIn     (busyIn),
    .sampleReady(sampleReady),
    .cntZero    (cntZero),
    .ctl        (ctl),
    .convN      (convN),
    .byteSel    (byteSel),
    .sampleValid(sampleValid),
    .timeoutErr (timeoutErr)
  );

  das_scan_dp #(
    .CH_W(CH_W), .SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .RISE_MAX(RISE_MAX), .FALL_MAX(FALL_MAX),
    .RDHI_CYC(RDHI_CYC), .RDLO_CYC(RDLO_CYC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .dataBus(dataBus),
    .cntZero(cntZero),
    .chSel  (muxAddr),
    .beat   (sampleData)
  );

endmodule

// File: rtl/das_scan_chk.sv
`timescale 1ns/1ps
module das_scan_chk #(
  parameter int CH_W      = 3,
  parameter int SAMPLE_W  = 12,
  parameter int SETUP_CYC = 13,
  parameter int PULSE_CYC = 13,
  parameter int RDLO_CYC  = 13
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [CH_W-1:0]          muxAddr,
  input logic                     convN,
  input logic                     byteSel,
  input logic                     busyIn,
  input logic                     sampleValid,
  input logic                     sampleReady,
  input logic [CH_W+SAMPLE_W-1:0] sampleData,
  input logic                     timeoutErr
);
  logic [CH_W-1:0] muxPrev;
  int muxRun, lowRun, selRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxPrev <= '0;
      muxRun  <= 0;
      lowRun  <= 0;
      selRun  <= 0;
    end else begin
      muxPrev <= muxAddr;
      muxRun  <= (muxAddr != muxPrev) ? 1 : ((muxRun < 1000000) ? muxRun + 1 : muxRun);
      lowRun  <= convN   ? 0 : lowRun + 1;
      selRun  <= byteSel ? selRun + 1 : 0;
    end
  end

  AST_MUX_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convN) |-> muxRun >= SETUP_CYC); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convN) |-> lowRun == PULSE_CYC); // R3
  AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muxAddr) |-> ($past(convN) && !$past(busyIn) && $past(sampleValid && sampleReady))); // R4
  AST_SEL_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(byteSel) |-> selRun >= RDLO_CYC); // R6
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !sampleReady) |=> (sampleValid && $stable(sampleData))); // R7
  AST_NO_CONV_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> convN); // R7
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !sampleValid); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr); // R9

endmodule

bind das_scan_ctrl das_scan_chk #(
  .CH_W(CH_W), .SAMPLE_W(SAMPLE_W),
  .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .RDLO_CYC(RDLO_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .muxAddr(muxAddr), .convN(convN), .byteSel(byteSel),
  .busyIn(busyIn), .sampleValid(sampleValid), .sampleReady(sampleReady),
  .sampleData(sampleData), .timeoutErr(timeoutErr)
);

// File: tb/tb_das_scan_ctrl.sv
`timescale 1ns/1ps
module tb_das_scan_ctrl;
  localparam int SETUP = 3, PULSE = 2, RISE = 6, FALL = 40, RDHI = 2, RDLO = 2;
  localparam int STDLY = 2, CONV = 20;

  logic clk = 1'b0, rstN = 1'b0, scanEn = 1'b0, sampleReady = 1'b0;
  logic busyIn;
  logic [7:0] dataBus;
  logic [2:0] muxAddr;
  logic convN, byteSel, sampleValid, timeoutErr;
  logic [14:0] sampleData;

  always #2 clk = ~clk;

  das_scan_ctrl #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .RISE_MAX(RISE), .FALL_MAX(FALL),
    .RDHI_CYC(RDHI), .RDLO_CYC(RDLO)
  ) dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .busyIn(busyIn), .dataBus(dataBus),
    .sampleReady(sampleReady), .muxAddr(muxAddr), .convN(convN), .byteSel(byteSel),
    .sampleValid(sampleValid), .sampleData(sampleData), .timeoutErr(timeoutErr)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] val(input logic [2:0] c, input logic [11:0] s);
    return 12'({9'd0, c} * 12'h2D3) + s;
  endfunction

  // behavioural converter
  logic noRise = 1'b0, noFall = 1'b0;
  logic [11:0] salt = '0;
  logic prevConv;
  int phase, mcnt;
  logic [2:0] mch;
  logic [11:0] res;

  always @(posedge clk) begin
    if (!rstN) begin
      busyIn <= 1'b0; phase <= 0; mcnt <= 0; prevConv <= 1'b1; res <= '0; mch <= '0;
    end else begin
      prevConv <= convN;
      case (phase)
        0: if (prevConv && !convN && !busyIn) begin phase <= 1; mcnt <= 1; mch <= muxAddr; end
        1: if (mcnt >= STDLY) begin
             if (noRise) phase <= 0;
             else begin busyIn <= 1'b1; phase <= 2; mcnt <= 0; end
           end else mcnt <= mcnt + 1;
        2: begin
             mcnt <= mcnt + 1;
             if (mcnt >= CONV && !noFall) begin busyIn <= 1'b0; res <= val(mch, salt); phase <= 0; end
           end
        default: phase <= 0;
      endcase
    end
  end
  // padded lines of the second read carry a nonzero pattern
  assign dataBus = !convN ? 8'h5A : (byteSel ? {res[3:0], 4'b1010} : res[11:4]);

  // monitors at the falling edge
  int cyc = 0, fallCount = 0, errCount = 0, acceptN = 0;
  int lastFallCyc = 0, lastErrCyc = 0, muxRun = 0, lowRun = 0;
  int setupViol = 0, pulseViol = 0, holdViol = 0;
  logic [14:0] acc [0:63];
  logic prevConvMon = 1'b1;
  logic [2:0] muxPrevMon = '0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (muxAddr != muxPrevMon) begin
        muxRun = 1;
        if (busyIn || !convN || !prevConvMon) holdViol++;
      end else muxRun++;
      if (prevConvMon && !convN) begin
        fallCount++; lastFallCyc = cyc;
        if (muxRun < SETUP + 1) setupViol++;
      end
      if (!convN) lowRun++;
      else begin
        if (!prevConvMon && lowRun != PULSE) pulseViol++;
        lowRun = 0;
      end
      if (timeoutErr) begin errCount++; lastErrCyc = cyc; end
      if (sampleValid && sampleReady) begin
        if (acceptN < 64) acc[acceptN] = sampleData;
        acceptN++;
      end
      prevConvMon = convN;
      muxPrevMon = muxAddr;
    end
  end

  int chNext = 0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    scanEn = 1'b0; sampleReady = 1'b1;
    step(200);
    if (acceptN > 0) chNext = (int'(acc[acceptN-1][14:12]) + 1) % 8;
  endtask

  task automatic t_reset();
    chk(convN == 1'b1, "R11 convN", 32'(convN), 1);
    chk(byteSel == 1'b0, "R11 byteSel", 32'(byteSel), 0);
    chk(muxAddr == 3'd0, "R11 muxAddr", 32'(muxAddr), 0);
    chk(sampleValid == 1'b0, "R11 sampleValid", 32'(sampleValid), 0);
    chk(timeoutErr == 1'b0, "R11 timeoutErr", 32'(timeoutErr), 0);
  endtask

  // R1 R5 R6: nine samples covering a full wrap
  task automatic t_scan(input logic [11:0] firstVal);
    int a0, c, k;
    logic [11:0] e;
    salt = firstVal - val(3'(chNext), 12'd0);
    a0 = acceptN;
    sampleReady = 1'b1; scanEn = 1'b1;
    k = 0;
    while (acceptN < a0 + 9 && k < 3000) begin step(1); k++; end
    drain();
    for (int i = 0; i < 9; i++) begin
      c = (chNext + 0) ; // placeholder overwritten below
      c = (int'(acc[a0][14:12]) + i) % 8;
      e = val(3'(c), salt);
      chk(acc[a0+i][14:12] == 3'(c), "R1 channel order", 32'(acc[a0+i][14:12]), 32'(c));
      chk(acc[a0+i][11:4] == e[11:4], "R5 high byte", 32'(acc[a0+i][11:4]), 32'(e[11:4]));
      chk(acc[a0+i][3:0] == e[3:0], "R6 low nibble", 32'(acc[a0+i][3:0]), 32'(e[3:0]));
    end
    chk(acc[a0][11:0] == firstVal, "R6 boundary value", 32'(acc[a0][11:0]), 32'(firstVal));
  endtask

  // R7: backpressure holds the beat, no new conversion
  task automatic t_backpressure();
    int f0, a0, k, c;
    logic [14:0] held;
    bit stableOk = 1'b1;
    c = chNext;
    sampleReady = 1'b0; scanEn = 1'b1;
    k = 0;
    while (!sampleValid && k < 500) begin step(1); k++; end
    scanEn = 1'b0;
    held = sampleData; f0 = fallCount; a0 = acceptN;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (!sampleValid || sampleData != held) stableOk = 1'b0;
    end
    chk(stableOk, "R7 beat held while not ready", 32'(sampleData), 32'(held));
    chk(fallCount == f0, "R7 no conversion while pending", 32'(fallCount), 32'(f0));
    chk(acceptN == a0, "R7 no accept while not ready", 32'(acceptN), 32'(a0));
    drain();
    chk(held == {3'(c), val(3'(c), salt)}, "R7 beat format", 32'(held), 32'({3'(c), val(3'(c), salt)}));
  endtask

  // R10: stop after the current channel
  task automatic t_stop();
    int f0, a0, k, c;
    c = chNext; f0 = fallCount; a0 = acceptN;
    sampleReady = 1'b1; scanEn = 1'b1;
    k = 0;
    while (fallCount == f0 && k < 200) begin step(1); k++; end
    scanEn = 1'b0;
    step(200);
    chk(fallCount == f0 + 1, "R10 single conversion", 32'(fallCount), 32'(f0 + 1));
    chk(acceptN == a0 + 1, "R10 current sample delivered", 32'(acceptN), 32'(a0 + 1));
    chk(acc[a0][14:12] == 3'(c), "R10 channel", 32'(acc[a0][14:12]), 32'(c));
    drain();
  endtask

  // R8/R9: timeouts, then retry of the same channel
  task automatic t_timeout(input bit rise);
    int f0, a0, e0, k, c, lat;
    c = chNext; f0 = fallCount; a0 = acceptN; e0 = errCount;
    if (rise) noRise = 1'b1; else noFall = 1'b1;
    sampleReady = 1'b1; scanEn = 1'b1;
    k = 0;
    while (fallCount == f0 && k < 200) begin step(1); k++; end
    scanEn = 1'b0;
    k = 0;
    while (errCount == e0 && k < 300) begin step(1); k++; end
    lat = lastErrCyc - lastFallCyc;
    if (rise) begin
      chk(errCount == e0 + 1, "R8 error pulse", 32'(errCount), 32'(e0 + 1));
      chk(lat == PULSE + RISE, "R8 error latency", 32'(lat), 32'(PULSE + RISE));
      chk(acceptN == a0, "R8 no sample", 32'(acceptN), 32'(a0));
    end else begin
      chk(errCount == e0 + 1, "R9 error pulse", 32'(errCount), 32'(e0 + 1));
      chk(lat >= FALL && lat <= FALL + PULSE + RISE, "R9 error latency", 32'(lat), 32'(FALL));
      chk(acceptN == a0, "R9 no sample", 32'(acceptN), 32'(a0));
    end
    step(3);
    chk(timeoutErr == 1'b0, rise ? "R8 pulse ends" : "R9 pulse ends", 32'(timeoutErr), 0);
    noRise = 1'b0; noFall = 1'b0;
    step(40);
    f0 = fallCount;
    scanEn = 1'b1;
    k = 0;
    while (fallCount == f0 && k < 200) begin step(1); k++; end
    scanEn = 1'b0;
    step(200);
    chk(acceptN == a0 + 1, rise ? "R8 retry delivers" : "R9 retry delivers", 32'(acceptN), 32'(a0 + 1));
    chk(acc[a0][14:12] == 3'(c), rise ? "R8 same channel" : "R9 same channel", 32'(acc[a0][14:12]), 32'(c));
    drain();
  endtask

  initial begin
    step(5);
    rstN = 1'b1;
    step(2);
    t_reset();
    t_scan(12'hFFF);
    t_scan(12'h000);
    t_backpressure();
    t_stop();
    t_timeout(1'b1);
    t_timeout(1'b0);
    chk(setupViol == 0, "R2 address setup", 32'(setupViol), 0);
    chk(pulseViol == 0, "R3 strobe width", 32'(pulseViol), 0);
    chk(holdViol == 0, "R4 address hold", 32'(holdViol), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(150000 * 4);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule